// File: doc/BRIEF.md
# Two-Layer Inference Sequencer

This block runs one forward pass of a small two-layer fully connected network. After a start pulse it fetches packed input rows and weight rows from two synchronous-read memories. It presents them to an external matrix-multiply unit through a stationary port and a moving port, each with a valid strobe. Every lane of every returned result row goes through a saturating sigmoid lookup. The hidden-layer activations are kept locally and fed back as the stationary operand of the second layer. The output-layer activations are written to an output memory. While a pass is in progress `ready` is low, and `done` pulses once at the end.

Values are signed 16-bit fixed point with 10 fraction bits, so 1.0 is `0x0400`. Four lanes are packed into each 64-bit word, lane j in bits [16j+15:16j]. The input and output memories hold 4 words. The weight memory holds 8 words: words 0 to 3 are the hidden-layer matrix and words 4 to 7 are the output-layer matrix. Bias is carried as the last column of each weight matrix, paired with a row of ones in the activation operand. Software supplies that row in the input memory for the first layer. The sequencer inserts it for the second layer.

Top module: `nn_seq_top`

## Requirements
- R1: After reset, `ready` is 1 and `done`, `outWe`, `inRdEn`, `wRdEn`, `mmStatValid` and `mmMoveValid` are 0.
- R2: A `start` sampled while `ready` is 1 begins a pass, and `ready` is 0 from the next cycle. `done` is a one-cycle pulse in the cycle after the last output write, and `ready` returns to 1 in the cycle after `done`.
- R3: A `start` sampled while `ready` is 0 is ignored: the pass still makes exactly four output writes and one `done` pulse.
- R4: In the hidden layer, stationary row r is input word r and moving row r is weight word r, for r = 0..3. They are presented in row order, one row per cycle, with both valid strobes high together.
- R5: In the output layer, moving row r is weight word 4+r. Stationary row r (r < 3) is the hidden activation row r. Stationary row 3 is four lanes of `0x0400`.
- R6: The sigmoid clamps each lane to [-8192, 8128] (-8.0 to 7.9375) and truncates it to a multiple of 1/16. For the truncated value x with a = |x|, it returns 1.0 when a >= 5, 0.03125a + 0.84375 when 2.375 <= a < 5, 0.125a + 0.625 when 1 <= a < 2.375, and 0.25a + 0.5 when a < 1. For negative x the result is 1.0 minus that value. The result is exact in the 16-bit format.
- R7: The sigmoid of the k-th output-layer result row is written to output word k, once per pass.
- R8: The sigmoid stage is registered: each hidden capture or output write happens exactly one cycle after its result row is valid on `mmResValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass (honoured only while ready) |
| ready | output | 1 | Idle and able to accept start |
| done | output | 1 | One-cycle pulse at the end of a pass |
| inRdEn | output | 1 | Input memory read enable |
| inRdAddr | output | 2 | Input memory word address |
| inRdData | input | 64 | Input memory read data, one cycle after the enable |
| wRdEn | output | 1 | Weight memory read enable |
| wRdAddr | output | 3 | Weight memory word address |
| wRdData | input | 64 | Weight memory read data, one cycle after the enable |
| mmStatValid | output | 1 | Stationary row valid |
| mmStatData | output | 64 | Stationary row, four lanes |
| mmMoveValid | output | 1 | Moving row valid |
| mmMoveData | output | 64 | Moving row, four lanes |
| mmResValid | input | 1 | Result row valid |
| mmResData | input | 64 | Result row, four lanes |
| outWe | output | 1 | Output memory write enable |
| outAddr | output | 2 | Output memory word address |
| outWrData | output | 64 | Output memory write data |

## Verification
The bench loads an identity matrix as input, so each hidden result equals a weight lane. It then sweeps weight lanes across the whole 16-bit range in steps of 64, plus the values on either side of both clamp limits, and observes the activations the block sends back as the second-layer stationary operand. A clamp that is off by one, or a table index taken from the wrong bits, shows up as a wrong activation near ±8 or throughout the table. A missing bias-row substitution gives a final row other than 0.75 in every lane. A start that is not masked while busy gives extra writes or a second done pulse. The result latency and the gaps between result rows are varied, so a sequencer that counts cycles instead of result strobes, or that changes layer on the wrong strobe, writes shifted or stale rows.

// File: rtl/nn_seq_pkg.sv
package nn_seq_pkg;
  localparam int LANES    = 4;
  localparam int ROWS     = LANES;
  localparam int ROW_W    = $clog2(ROWS);
  localparam int TBL_BITS = 8;
  localparam int TBL_SIZE = 1 << TBL_BITS;

  typedef struct packed {
    logic             issue;
    logic [ROW_W-1:0] issueRow;
    logic             layer;
    logic [ROW_W-1:0] resRow;
  } ctrl_t;

  // One table entry; idx is the two's-complement input in 1/16 steps.
  function automatic int sigEntry(input int idx, input int frac);
    int s, a, one, f;
    s   = (idx >= TBL_SIZE / 2) ? idx - TBL_SIZE : idx;
    a   = (s < 0) ? -s : s;
    one = 1 << frac;
    if (a >= 80)      f = one;
    else if (a >= 38) f = ((a * one) >> 9) + ((27 * one) >> 5);
    else if (a >= 16) f = ((a * one) >> 7) + ((5 * one) >> 3);
    else              f = ((a * one) >> 6) + (one >> 1);
    if (s < 0) f = one - f;
    return f;
  endfunction
endpackage

// File: rtl/nn_seq_sigmoid.sv
module nn_seq_sigmoid
  import nn_seq_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int FRAC   = 10,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  output logic              outValid,
  output logic [WORD_W-1:0] outData
);
  localparam logic signed [LANE_W-1:0] HI_LIM = LANE_W'((8 << FRAC) - (1 << (FRAC - 4)));
  localparam logic signed [LANE_W-1:0] LO_LIM = LANE_W'(-(8 << FRAC));

  logic [LANE_W-1:0] lut [TBL_SIZE];

  for (genvar e = 0; e < TBL_SIZE; e++) begin : g_lut
    assign lut[e] = LANE_W'(sigEntry(e, FRAC));
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [LANE_W-1:0] laneIn, clamped;
    assign laneIn = inData[g*LANE_W +: LANE_W];
    always_comb begin
      if (laneIn > HI_LIM)      clamped = HI_LIM;
      else if (laneIn < LO_LIM) clamped = LO_LIM;
      else                      clamped = laneIn;
    end
    always_ff @(posedge clk) begin
      outData[g*LANE_W +: LANE_W] <= lut[clamped[FRAC+3:FRAC-4]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/nn_seq_ctrl.sv
module nn_seq_ctrl
  import nn_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  sigValid,
  output ctrl_t ctl,
  output logic  ready,
  output logic  done
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_COLLECT, S_FIN} state_t;

  state_t           state;
  logic             layer;
  logic [ROW_W-1:0] issueRow, resRow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      layer    <= 1'b0;
      issueRow <= '0;
      resRow   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state    <= S_ISSUE;
          layer    <= 1'b0;
          issueRow <= '0;
          resRow   <= '0;
        end
        S_ISSUE: begin
          if (issueRow == ROW_W'(ROWS - 1)) begin
            issueRow <= '0;
            state    <= S_COLLECT;
          end else begin
            issueRow <= issueRow + 1'b1;
          end
        end
        S_COLLECT: if (sigValid) begin
          if (resRow == ROW_W'(ROWS - 1)) begin
            resRow <= '0;
            if (!layer) begin
              layer <= 1'b1;
              state <= S_ISSUE;
            end else begin
              state <= S_FIN;
            end
          end else begin
            resRow <= resRow + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.issue    = (state == S_ISSUE);
    ctl.issueRow = issueRow;
    ctl.layer    = layer;
    ctl.resRow   = resRow;
  end

  assign ready = (state == S_IDLE);
  assign done  = (state == S_FIN);
endmodule

// File: rtl/nn_seq_dp.sv
module nn_seq_dp
  import nn_seq_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int FRAC   = 10,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  output logic              sigValid,
  output logic              inRdEn,
  output logic [ROW_W-1:0]  inRdAddr,
  input  logic [WORD_W-1:0] inRdData,
  output logic              wRdEn,
  output logic [ROW_W:0]    wRdAddr,
  input  logic [WORD_W-1:0] wRdData,
  output logic              mmStatValid,
  output logic [WORD_W-1:0] mmStatData,
  output logic              mmMoveValid,
  output logic [WORD_W-1:0] mmMoveData,
  input  logic              mmResValid,
  input  logic [WORD_W-1:0] mmResData,
  output logic              outWe,
  output logic [ROW_W-1:0]  outAddr,
  output logic [WORD_W-1:0] outWrData
);
  localparam logic [WORD_W-1:0] ONES_ROW = {LANES{LANE_W'(1 << FRAC)}};

  logic              pendValid, pendLayer;
  logic [ROW_W-1:0]  pendRow;
  logic [WORD_W-1:0] actBuf [ROWS];
  logic [WORD_W-1:0] sigData;

  assign inRdEn   = ctl.issue & ~ctl.layer;
  assign inRdAddr = ctl.issueRow;
  assign wRdEn    = ctl.issue;
  assign wRdAddr  = {ctl.layer, ctl.issueRow};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendLayer <= 1'b0;
      pendRow   <= '0;
    end else begin
      pendValid <= ctl.issue;
      pendLayer <= ctl.layer;
      pendRow   <= ctl.issueRow;
    end
  end

  assign mmStatValid = pendValid;
  assign mmMoveValid = pendValid;
  assign mmMoveData  = wRdData;
  always_comb begin
    if (!pendLayer)                          mmStatData = inRdData;
    else if (pendRow == ROW_W'(ROWS - 1))    mmStatData = ONES_ROW;
    else                                     mmStatData = actBuf[pendRow];
  end

  nn_seq_sigmoid #(.LANE_W(LANE_W), .FRAC(FRAC)) u_sig (
    .clk(clk), .rstN(rstN),
    .inValid(mmResValid), .inData(mmResData),
    .outValid(sigValid), .outData(sigData)
  );

  always_ff @(posedge clk) begin
    if (sigValid && !ctl.layer) actBuf[ctl.resRow] <= sigData;
  end

  assign outWe     = sigValid & ctl.layer;
  assign outAddr   = ctl.resRow;
  assign outWrData = sigData;
endmodule

// File: rtl/nn_seq_top.sv
module nn_seq_top
  import nn_seq_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int FRAC   = 10,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              ready,
  output logic              done,
  output logic              inRdEn,
  output logic [ROW_W-1:0]  inRdAddr,
  input  logic [WORD_W-1:0] inRdData,
  output logic              wRdEn,
  output logic [ROW_W:0]    wRdAddr,
  input  logic [WORD_W-1:0] wRdData,
  output logic              mmStatValid,
  output logic [WORD_W-1:0] mmStatData,
  output logic              mmMoveValid,
  output logic [WORD_W-1:0] mmMoveData,
  input  logic              mmResValid,
  input  logic [WORD_W-1:0] mmResData,
  output logic              outWe,
  output logic [ROW_W-1:0]  outAddr,
  output logic [WORD_W-1:0] outWrData
);
  ctrl_t ctl;
  logic  sigValid;

  nn_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sigValid(sigValid),
    .ctl(ctl), .ready(ready), .done(done)
  );

  nn_seq_dp #(.LANE_W(LANE_W), .FRAC(FRAC)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sigValid(sigValid),
    .inRdEn(inRdEn), .inRdAddr(inRdAddr), .inRdData(inRdData),
    .wRdEn(wRdEn), .wRdAddr(wRdAddr), .wRdData(wRdData),
    .mmStatValid(mmStatValid), .mmStatData(mmStatData),
    .mmMoveValid(mmMoveValid), .mmMoveData(mmMoveData),
    .mmResValid(mmResValid), .mmResData(mmResData),
    .outWe(outWe), .outAddr(outAddr), .outWrData(outWrData)
  );
endmodule

// File: rtl/nn_seq_chk.sv
module nn_seq_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic ready,
  input logic done,
  input logic mmStatValid,
  input logic mmResValid,
  input logic outWe
);
  // R2
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> !ready);
  // R2
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> ready);
  // R2
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> $past(outWe));
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN) (start && ready) |=> !ready);
  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN) (start && !ready && !done) |=> !ready);
  // R4
  feed_busy_chk: assert property (@(posedge clk) disable iff (!rstN) mmStatValid |-> !ready);
  // R8
  sig_latency_chk: assert property (@(posedge clk) disable iff (!rstN) outWe |-> $past(mmResValid));
  // R7
  write_busy_chk: assert property (@(posedge clk) disable iff (!rstN) outWe |-> !ready);
endmodule

bind nn_seq_top nn_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .ready(ready), .done(done),
  .mmStatValid(mmStatValid), .mmResValid(mmResValid), .outWe(outWe)
);

// File: tb/sim_nn_seq_top.sv
module sim_nn_seq_top;
  logic        clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic        ready, done, inRdEn, wRdEn, mmStatValid, mmMoveValid, outWe;
  logic        mmResValid = 1'b0;
  logic [1:0]  inRdAddr, outAddr;
  logic [2:0]  wRdAddr;
  logic [63:0] inRdData = '0, wRdData = '0, mmResData = '0;
  logic [63:0] mmStatData, mmMoveData, outWrData;

  always #2 clk = ~clk;

  nn_seq_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .ready(ready), .done(done),
    .inRdEn(inRdEn), .inRdAddr(inRdAddr), .inRdData(inRdData),
    .wRdEn(wRdEn), .wRdAddr(wRdAddr), .wRdData(wRdData),
    .mmStatValid(mmStatValid), .mmStatData(mmStatData),
    .mmMoveValid(mmMoveValid), .mmMoveData(mmMoveData),
    .mmResValid(mmResValid), .mmResData(mmResData),
    .outWe(outWe), .outAddr(outAddr), .outWrData(outWrData)
  );

  localparam logic [63:0] ONES = 64'h0400_0400_0400_0400;

  int nChecks = 0, nFails = 0;
  int cyc = 0, writeCnt = 0, doneCnt = 0, lastRes = 0, lastWr = 0, lastDone = 0;
  int resLat = 2, resGap = 0;
  logic [63:0] inMem [4], wMem [8], outMem [4];
  logic [63:0] statLog [8], moveLog [8], resQ [4];
  int loadCnt, emitIdx, waitCnt;
  bit emitting;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mmRow(input logic [63:0] w, input logic [63:0] s0,
                                        input logic [63:0] s1, input logic [63:0] s2,
                                        input logic [63:0] s3);
    logic [63:0] s [4];
    logic [63:0] r;
    s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
    for (int j = 0; j < 4; j++) begin
      longint acc = 0;
      for (int k = 0; k < 4; k++)
        acc += longint'($signed(w[16*k +: 16])) * longint'($signed(s[k][16*j +: 16]));
      acc = acc >>> 10;
      if (acc > 32767) acc = 32767;
      if (acc < -32768) acc = -32768;
      r[16*j +: 16] = 16'(acc);
    end
    return r;
  endfunction

  // Sigmoid per R6, evaluated in real arithmetic
  function automatic logic [15:0] sigRef(input logic [15:0] v);
    int x, s, a, q;
    real f;
    x = int'($signed(v));
    if (x > 8128) x = 8128;
    if (x < -8192) x = -8192;
    s = x >>> 6;
    a = (s < 0) ? -s : s;
    if (a >= 80)      f = 1.0;
    else if (a >= 38) f = 0.03125 * (a / 16.0) + 0.84375;
    else if (a >= 16) f = 0.125 * (a / 16.0) + 0.625;
    else              f = 0.25 * (a / 16.0) + 0.5;
    q = $rtoi(f * 1024.0 + 0.5);
    if (s < 0) q = 1024 - q;
    return 16'(q);
  endfunction

  function automatic logic [63:0] sigWord(input logic [63:0] w);
    logic [63:0] r;
    for (int j = 0; j < 4; j++) r[16*j +: 16] = sigRef(w[16*j +: 16]);
    return r;
  endfunction

  function automatic logic [63:0] rndWord(input int amp);
    logic [63:0] r;
    for (int j = 0; j < 4; j++) r[16*j +: 16] = 16'($urandom_range(0, 2 * amp) - amp);
    return r;
  endfunction

  // Memories and event tracking
  always @(posedge clk) begin
    if (inRdEn) inRdData <= inMem[inRdAddr];
    if (wRdEn)  wRdData  <= wMem[wRdAddr];
    if (outWe) begin
      outMem[outAddr] <= outWrData;
      writeCnt <= writeCnt + 1;
      lastWr <= cyc;
    end
    if (done) begin
      doneCnt <= doneCnt + 1;
      lastDone <= cyc;
    end
    if (mmResValid) lastRes <= cyc;
    cyc <= cyc + 1;
  end

  // Behavioural matrix-multiply unit
  always @(posedge clk) begin
    mmResValid <= 1'b0;
    if (!rstN) begin
      loadCnt = 0;
      emitting = 0;
    end else begin
      if (emitting) begin
        if (waitCnt > 0) waitCnt--;
        else begin
          mmResValid <= 1'b1;
          mmResData  <= resQ[emitIdx];
          emitIdx++;
          waitCnt = resGap;
          if (emitIdx == 4) emitting = 0;
        end
      end
      if (mmStatValid) begin
        statLog[loadCnt] = mmStatData;
        moveLog[loadCnt] = mmMoveData;
        if (loadCnt % 4 == 3) begin
          int b;
          b = loadCnt - 3;
          for (int r = 0; r < 4; r++)
            resQ[r] = mmRow(moveLog[b+r], statLog[b], statLog[b+1], statLog[b+2], statLog[b+3]);
          emitting = 1;
          emitIdx = 0;
          waitCnt = resLat;
        end
        loadCnt = (loadCnt + 1) % 8;
      end
    end
  end

  task automatic runPass(input int lat, input int gap, input bit poke);
    logic [63:0] hid [4], expOut [4];
    int w0, d0, n;
    bit busyOk;
    for (int r = 0; r < 3; r++) hid[r] = sigWord(mmRow(wMem[r], inMem[0], inMem[1], inMem[2], inMem[3]));
    hid[3] = ONES;
    for (int r = 0; r < 4; r++) expOut[r] = sigWord(mmRow(wMem[4+r], hid[0], hid[1], hid[2], hid[3]));
    resLat = lat; resGap = gap;
    w0 = writeCnt; d0 = doneCnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(ready == 1'b0, "R2 ready low after start", 64'(ready), 64'd0);
    n = 0; busyOk = 1;
    while (!done && n < 1000) begin
      if (ready) busyOk = 0;
      start = (poke && n >= 3 && n < 6);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(done && busyOk, "R2 busy until done", {62'd0, done, busyOk}, 64'd3);
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R2 ready after done", 64'(ready), 64'd1);
    chk(lastDone == lastWr + 1, "R2 done follows last write", 64'(lastDone), 64'(lastWr + 1));
    chk(lastWr == lastRes + 1, "R8 one-cycle sigmoid latency", 64'(lastWr), 64'(lastRes + 1));
    chk(writeCnt - w0 == 4, "R3 R7 write count", 64'(writeCnt - w0), 64'd4);
    chk(doneCnt - d0 == 1, "R3 done count", 64'(doneCnt - d0), 64'd1);
    for (int r = 0; r < 4; r++) begin
      chk(statLog[r] == inMem[r], "R4 hidden stationary row", statLog[r], inMem[r]);
      chk(moveLog[r] == wMem[r], "R4 hidden moving row", moveLog[r], wMem[r]);
      chk(moveLog[4+r] == wMem[4+r], "R5 output moving row", moveLog[4+r], wMem[4+r]);
      chk(statLog[4+r] == hid[r], (r == 3) ? "R5 bias row" : "R6 hidden activation",
          statLog[4+r], hid[r]);
      chk(outMem[r] == expOut[r], "R7 output word", outMem[r], expOut[r]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 idle state after reset
    chk(ready == 1'b1, "R1 ready", 64'(ready), 64'd1);
    chk({done, outWe, inRdEn, wRdEn, mmStatValid, mmMoveValid} == 6'd0, "R1 idle strobes",
        64'({done, outWe, inRdEn, wRdEn, mmStatValid, mmMoveValid}), 64'd0);

    // Identity inputs: hidden result equals hidden weights
    for (int r = 0; r < 4; r++) inMem[r] = 64'h0400 << (16 * r);
    for (int r = 0; r < 8; r++) wMem[r] = '0;
    wMem[7] = 64'h0400_0000_0000_0000;
    runPass(2, 0, 0);
    chk(outMem[3] == 64'h0300_0300_0300_0300, "R5 bias row gives sigmoid(1.0)",
        outMem[3], 64'h0300_0300_0300_0300);

    // Clamp edges and sign boundaries (R6)
    wMem[0] = {16'd8128, 16'd8129, 16'd8191, 16'sd32767};
    wMem[1] = {-16'sd8192, -16'sd8193, -16'sd8129, -16'sd32768};
    wMem[2] = {16'd63, 16'd64, -16'sd1, 16'd0};
    runPass(0, 0, 0);

    // Sweep of the full 16-bit range in steps of 64 (R6)
    for (int p = 0; p < 86; p++) begin
      for (int r = 0; r < 3; r++)
        for (int j = 0; j < 4; j++)
          wMem[r][16*j +: 16] = 16'(-32768 + 64 * ((p * 12 + r * 4 + j) % 1024));
      for (int r = 4; r < 8; r++) wMem[r] = rndWord(4096);
      runPass(p % 4, (p / 4) % 3, 0);
    end

    // General operands with varied latency and gaps
    for (int p = 0; p < 24; p++) begin
      for (int r = 0; r < 3; r++) inMem[r] = rndWord(8 << (p % 4) * 2);
      inMem[3] = ONES;
      for (int r = 0; r < 8; r++) wMem[r] = rndWord(512 << (p % 5));
      runPass(p % 5, p % 3, p % 2);
    end

    // Start held while busy is ignored (R3)
    runPass(4, 2, 1);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule